// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block takes two free-running clocks, which need not be related to each other, and drives one output clock taken from whichever source the select input names. A change of selection never shortens a high or a low phase on the output. The source that is leaving is first parked low on one of its own falling edges. Only after that is the incoming source let through, starting on one of its rising edges. Each source has its own lane, which holds a short flop chain on that source's clock. The lanes pass a handshake to each other through these chains, so a lane may open only after the other lane has fully drained.

A level-sensitive force input covers the case where the outgoing clock has died. While force is high, the lane that is not selected is cleared at once, with no help from its own clock. The selected lane opens without waiting for the other lane to drain. Holding force high also makes a system that has only one clock source possible: the unused input may sit idle.

Top module: `clk_switch_glitchless`

## Requirements
- R1: While `rst_n` is low, both lane enables are cleared and `clk_out` stays low once each running source has seen a falling edge.
- R2: Once reset is released and the switch has settled, `clk_out` follows `clk_a` when `sel` is 0 and `clk_b` when `sel` is 1. Writing the value `sel` already holds causes no handover.
- R3: After `sel` changes, `clk_out` is parked low at a falling edge of the outgoing clock, no later than its third falling edge.
- R4: Once parked, `clk_out` stays low for at most three cycles of the incoming clock and then resumes on a rising edge of that clock.
- R5: No high or low phase of `clk_out` is shorter than the shortest half period of either source.
- R6: The two lane enables are never high at the same time, so `clk_out` never carries the OR of both sources.
- R7: Toggling `sel` back before a handover has completed still ends with the last selected source on `clk_out` and no runt phase.
- R8: With `force_sel` high, the enable of the lane that is not selected is cleared without any edge on its clock. The selected clock then reaches `clk_out` within three of its own cycles, even when the old clock has stopped.
- R9: With `force_sel` held high, the block comes out of reset and runs from the selected input while the other input is idle.
- R10: Each lane enable changes only while that lane's clock is low, except when a force clear acts on it.
- R11: Outside force mode, a lane enable rises only while the other lane's enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source clock 0, chosen when `sel` is 0 |
| clk_b | input | 1 | Source clock 1, chosen when `sel` is 1 |
| sel | input | 1 | Source select, asynchronous to both clocks |
| force_sel | input | 1 | Level input: clear the lane that is not selected at once and skip the drain wait |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each source domain |
| clk_out | output | 1 | Gated output clock |

## Verification
The assertions check three properties on every cycle. The two enables are never high together. Each enable moves only during its own clock's low phase. An enable opens only after the other lane is seen closed, and under force the lane that is not selected stays cleared. The bench scenarios are the only way to show the timing seen at the output pin. This covers how many outgoing falling edges pass before the park and how many incoming cycles pass before the resume. It also covers the absence of short pulses under random select toggles between unrelated clock periods, the recovery from a stopped source under force, and start-up with one input idle.

// File: rtl/clksw_pkg.sv
// Shared constants and types for the glitch-free clock switch.
// Assumes exactly two sources; the select input is one bit wide.
package clksw_pkg;
    localparam int unsigned SRC_COUNT = 2;
    localparam int unsigned SEL_W     = $clog2(SRC_COUNT);

    typedef logic [SRC_COUNT-1:0] src_vec_t;
endpackage

// File: rtl/clksw_sync.sv
// Multi-stage synchronizer on one source clock.
// Carries a level from another domain into this clock's domain. The
// asynchronous clear lets a force path empty the chain with no clock edge.
// The synchronous active-low reset empties it while the clock runs.
// Assumes STAGES >= 2.
module clksw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q,
    output logic any
);
    logic [STAGES-1:0] stg;

    // Shift the incoming level through the chain on each rising edge.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            stg <= '0;
        end else if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    // Last stage drives the enable flop; any stage set marks the lane busy.
    always_comb begin
        q   = stg[STAGES-1];
        any = |stg;
    end
endmodule

// File: rtl/clksw_lane.sv
// One source lane of the clock switch.
// Requests its clock when selected and the other lane is idle, or at once
// when force is high. The request is synchronized on this clock. The enable
// is updated on falling edges, so it only moves while the clock is low.
// Assumes the other lane's busy and enable come from a different clock.
module clksw_lane #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_sel,
    input  logic want,
    input  logic other_busy,
    input  logic other_en,
    output logic busy,
    output logic en
);
    logic kill;
    logic req;
    logic sync_q;
    logic sync_any;
    logic en_q;
    logic en_at_rise;

    // Force clear when not selected; request when selected and path free.
    always_comb begin
        kill = force_sel & ~want;
        req  = want & (force_sel | ~other_busy);
    end

    clksw_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (kill),
        .d     (req),
        .q     (sync_q),
        .any   (sync_any)
    );

    // Enable flop on the falling edge, so changes land in the low phase.
    always_ff @(negedge clk or posedge kill) begin
        if (kill) begin
            en_q <= 1'b0;
        end else if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= sync_q;
        end
    end

    // Expose enable and busy (anything in flight) to the other lane.
    always_comb begin
        en   = en_q;
        busy = sync_any | en_q;
    end

    // Capture the enable at each rising edge for the low-phase check.
    always_ff @(posedge clk or posedge kill) begin
        if (kill) begin
            en_at_rise <= 1'b0;
        end else begin
            en_at_rise <= en_q;
        end
    end

    // R10: enable is unchanged across the high phase of its clock.
    p_en_low_phase_r10: assert property (@(negedge clk) disable iff (!rst_n || kill)
        en_q == en_at_rise)
        else $error("p_en_low_phase_r10");

    // R11: enable rises only while the other lane is closed.
    p_en_after_other_r11: assert property (@(posedge clk) disable iff (!rst_n || force_sel)
        $rose(en_q) |-> !other_en)
        else $error("p_en_after_other_r11");
endmodule

// File: rtl/clk_switch_glitchless.sv
// Glitch-free two-source clock switch (top).
// Builds one lane per source and gates each source with its own enable.
// The output is the OR of the gated sources. The lanes exchange busy and
// enable so that only one is open at a time. Assumes sel and force_sel
// are asynchronous levels and that rst_n is held for a few cycles of each
// running source.
module clk_switch_glitchless
    import clksw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    input  logic force_sel,
    input  logic rst_n,
    output logic clk_out
);
    src_vec_t clk_in;
    src_vec_t en;
    src_vec_t busy;

    // Collect the source clocks into a vector indexed by select value.
    always_comb begin
        clk_in = {clk_b, clk_a};
    end

    for (genvar g = 0; g < SRC_COUNT; g++) begin : g_lane
        localparam int unsigned OTHER = SRC_COUNT - 1 - g;
        clksw_lane #(.STAGES(SYNC_STAGES)) u_lane (
            .clk        (clk_in[g]),
            .rst_n      (rst_n),
            .force_sel  (force_sel),
            .want       (sel == SEL_W'(g)),
            .other_busy (busy[OTHER]),
            .other_en   (en[OTHER]),
            .busy       (busy[g]),
            .en         (en[g])
        );
    end

    // Gate each source with its enable and merge onto the output.
    always_comb begin
        clk_out = |(clk_in & en);
    end

    // R6: never both lanes open, checked in each domain.
    p_one_source_a_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(en[0] && en[1]))
        else $error("p_one_source_a_r6");
    p_one_source_b_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(en[0] && en[1]))
        else $error("p_one_source_b_r6");

    // R8: under force, the lane not selected is closed, seen from the live clock.
    p_force_drop_a_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
        (force_sel && sel) |-> !en[0])
        else $error("p_force_drop_a_r8");
    p_force_drop_b_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
        (force_sel && !sel) |-> !en[1])
        else $error("p_force_drop_b_r8");
endmodule

// File: tb/sim_clk_switch_glitchless.sv
`timescale 1ps/1ps
// Bench for the glitch-free clock switch. clk_a runs at 200 MHz. clk_b has
// an unrelated period and an odd phase, so edges of the two never coincide.
module sim_clk_switch_glitchless;
    localparam int HALF_A   = 2500;
    localparam int HALF_B   = 3658;
    localparam int MIN_HALF = 2500;
    localparam int NV       = 8;
    localparam bit VSEL [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int VGAP [NV] = '{40000, 13001, 20000, 9777, 30000, 15555, 25000, 11111};

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic sel = 1'b0;
    logic force_sel = 1'b0;
    logic rst_n = 1'b0;
    logic clk_out;
    bit   run_a = 1'b1;
    bit   run_b = 1'b1;
    bit   mon_on = 1'b0;
    int   total = 0;
    int   bad = 0;
    int   pulse_bad = 0;
    realtime t_last = 0;

    clk_switch_glitchless u0 (
        .clk_a     (clk_a),
        .clk_b     (clk_b),
        .sel       (sel),
        .force_sel (force_sel),
        .rst_n     (rst_n),
        .clk_out   (clk_out)
    );

    always #HALF_A if (run_a) clk_a = ~clk_a;
    initial begin
        #1001;
        forever #HALF_B if (run_b) clk_b = ~clk_b;
    end

    // R5: measure every output phase against the shortest source half period.
    always @(clk_out) begin
        if (mon_on && (clk_out === 1'b0 || clk_out === 1'b1)) begin
            if ($realtime - t_last < MIN_HALF - 1) begin
                pulse_bad++;
                $display("FAIL R5 short phase: got %0t expected >= %0d", $realtime - t_last, MIN_HALF);
            end
        end
        t_last = $realtime;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_edge(input bit which, input bit rising);
        if (which) begin
            if (rising) @(posedge clk_b); else @(negedge clk_b);
        end else begin
            if (rising) @(posedge clk_a); else @(negedge clk_a);
        end
    endtask

    // R2 and R6: output equals the chosen source at mid-phase points.
    task automatic check_track(input bit src, input string req);
        int errs = 0;
        repeat (3) begin
            wait_edge(src, 1'b1); #200;
            if (clk_out !== 1'b1) errs++;
            wait_edge(src, 1'b0); #200;
            if (clk_out !== 1'b0) errs++;
        end
        check(errs == 0, req, "output tracks source", errs, 0);
    endtask

    // R3: count falling edges of the outgoing clock until the output stays low.
    task automatic measure_park(input bit old, output int n);
        n = 0;
        while (n < 8) begin
            wait_edge(old, 1'b0);
            n++;
            wait_edge(old, 1'b1); #100;
            if (clk_out === 1'b0) break;
        end
    endtask

    // R4: count rising edges of the incoming clock until the output is high.
    task automatic measure_resume(input bit nsrc, output int n);
        n = 0;
        while (n < 8) begin
            wait_edge(nsrc, 1'b1); #100;
            n++;
            if (clk_out === 1'b1) break;
        end
    endtask

    initial begin
        #400_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int errs;
        int n;
        bit cur;
        bit prev;

        // R1: output held low during reset with both clocks running.
        #20000;
        errs = 0;
        repeat (20) begin
            #1300;
            if (clk_out !== 1'b0) errs++;
        end
        check(errs == 0, "R1", "low during reset", errs, 0);

        // R2: after release, the source named by sel (0 -> clk_a) is used.
        rst_n = 1'b1;
        #60000;
        check_track(1'b0, "R2");
        mon_on = 1'b1;
        cur = 1'b0;

        // Vector table walk: R3/R4 on each change, R2/R6 tracking afterwards.
        for (int i = 0; i < NV; i++) begin
            #(VGAP[i]);
            prev = cur;
            cur  = VSEL[i];
            sel  = cur;
            if (prev != cur) begin
                measure_park(prev, n);
                check(n >= 1 && n <= 3, "R3", "falling edges to park", n, 3);
                measure_resume(cur, n);
                check(n <= 3, "R4", "cycles to resume", n, 3);
            end
            check_track(cur, (prev != cur) ? "R6" : "R2");
        end

        // R7: random toggles, some shorter than a full handover.
        for (int k = 0; k < 24; k++) begin
            sel = 1'($urandom % 2);
            #($urandom_range(300, 12000));
        end
        #400000;
        check_track(sel, "R7");
        sel = 1'b0;
        #400000;
        check_track(1'b0, "R7");

        // R8: stop clk_a low, then force over to clk_b.
        @(negedge clk_a);
        #1;
        run_a = 1'b0;
        #3000;
        force_sel = 1'b1;
        sel = 1'b1;
        measure_resume(1'b1, n);
        check(n <= 3, "R8", "forced resume cycles", n, 3);
        check_track(1'b1, "R8");

        // R9: reset with clk_a idle and force held; run from clk_b alone.
        mon_on = 1'b0;
        rst_n = 1'b0;
        #50000;
        check(clk_out === 1'b0, "R1", "low during forced reset", int'(clk_out), 0);
        rst_n = 1'b1;
        measure_resume(1'b1, n);
        check(n <= 4, "R9", "single-input start cycles", n, 4);
        check_track(1'b1, "R9");

        // R5: summary of the pulse-width monitor.
        check(pulse_bad == 0, "R5", "short phases seen", pulse_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule